// File: doc/BRIEF.md
# Pin Event and Task Bridge

This block sits between a bank of general-purpose pins and a chip-wide event/task fabric. On the input side it has eight event channels. Each channel picks one pin, resynchronises its level to the local clock and, while enabled, emits one-cycle pulses for a rising edge, a falling edge and for either edge. The pulses are grouped into three 8-bit vectors, each indexed by channel number. Any number of channels may watch the same pin.

On the output side the binding runs the other way. Every pin chooses one of eight task channels and has its own enable. Each task channel has three one-cycle inputs: set, clear and toggle. A pulse on a channel updates every enabled pin bound to that channel, all in the same clock. Configuration is reached through a plain register write/read port. Event channel c sits at address c. The pin bindings are packed four pins per 32-bit word, and word k sits at address 16+k.

Top module: `pin_event_task_unit`

## Requirements
- R1: While reset is held, and after it is released, every event output and every pin output is 0. Every configuration register reads 0.
- R2: A write to event channel c (address c) changes its settings at the next clock edge. A read returns pin select in bits 4:0 and enable in bit 8, and all other bits read as zero.
- R3: Take an enabled event channel whose selected pin changes level. Three clock edges after the change, the channel raises exactly one of rise or fall (rise for 0 to 1, fall for 1 to 0) together with any, for exactly one cycle.
- R4: An event channel whose enable bit is 0 produces no pulse on any of its three outputs.
- R5: Several event channels that select the same pin each produce their own pulses in the same cycle.
- R6: An event channel whose pin select is not less than NUM_PINS never pulses.
- R7: Pin n is bound by byte n%4 of the word at address 16+n/4. In that byte, bit 0 is the task enable and bits 3:1 are the task channel. Bits 7:4 read as zero, and writes reach the binding at the next clock edge.
- R8: A set, clear or toggle pulse on task channel t changes, at the next clock edge, the output of every enabled pin bound to t, all in the same cycle. Set drives 1, clear drives 0 and toggle inverts.
- R9: When several task pulses reach the same pin in one cycle, set takes priority over clear, and clear takes priority over toggle.
- R10: A pin whose task enable is 0 keeps its output level, whatever task pulses arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| evt_rise | output | 8 | Rising-edge event pulse per channel |
| evt_fall | output | 8 | Falling-edge event pulse per channel |
| evt_any | output | 8 | Either-edge event pulse per channel |
| task_set | input | 8 | Set task pulse per channel |
| task_clr | input | 8 | Clear task pulse per channel |
| task_tog | input | 8 | Toggle task pulse per channel |
| pin_out | output | NUM_PINS | Task-controlled pin output levels |

## Verification
Suppose a channel's stored pin select or enable is wrong. The fault shows up on the next read of that address, and also as a missing, extra or misplaced pulse three edges after a pin change. A wrong edge history register shows up as a pulse of the wrong polarity, or as a pulse that lasts two cycles. A mis-decoded pin binding field, or a wrong task priority, drives the wrong level on pin_out at the first edge after a task pulse. Random toggling then carries that error forward, so it keeps showing in every later compare.

// File: rtl/pet_pkg.sv
package pet_pkg;
  localparam int EVT_CH = 8;
  localparam int TSK_CH = 8;
  localparam int CH_W   = $clog2(TSK_CH);
  localparam int SEL_W  = 5;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int PINS_PER_WORD = 4;

  localparam logic [2:0] EVT_PAGE = 3'b000;
  localparam logic [2:0] TSK_PAGE = 3'b010;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } evt_cfg_t;

  typedef struct packed {
    logic [CH_W-1:0] ch;
    logic            en;
  } tsk_cfg_t;
endpackage

// File: rtl/pet_sync.sv
module pet_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pet_evt_chan.sv
module pet_evt_chan
  import pet_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_lvl,
  input  evt_cfg_t            cfg,
  output logic                rise,
  output logic                fall,
  output logic                any
);
  logic cur;
  logic prev_q;
  logic rise_d, fall_d, any_d;

  always_comb begin
    cur = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (cfg.sel == SEL_W'(i)) cur = pin_lvl[i];
    end
  end

  always_comb begin
    rise_d = cfg.en & cur & ~prev_q;
    fall_d = cfg.en & ~cur & prev_q;
    any_d  = cfg.en & (cur ^ prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      rise   <= 1'b0;
      fall   <= 1'b0;
      any    <= 1'b0;
    end else begin
      prev_q <= cur;
      rise   <= rise_d;
      fall   <= fall_d;
      any    <= any_d;
    end
  end

  AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |=> !(rise || fall || any)); // R4
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall)); // R3
  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R3
  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R3
endmodule

// File: rtl/pet_task_pin.sv
module pet_task_pin
  import pet_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tsk_cfg_t          cfg,
  input  logic [TSK_CH-1:0] task_set,
  input  logic [TSK_CH-1:0] task_clr,
  input  logic [TSK_CH-1:0] task_tog,
  output logic              lvl
);
  logic s, c, t;
  logic lvl_d;
  logic lvl_en;

  always_comb begin
    s = task_set[cfg.ch];
    c = task_clr[cfg.ch];
    t = task_tog[cfg.ch];
    lvl_en = cfg.en & (s | c | t);
    if (s)      lvl_d = 1'b1;
    else if (c) lvl_d = 1'b0;
    else        lvl_d = ~lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl <= 1'b0;
    else if (lvl_en) lvl <= lvl_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && task_set[cfg.ch]) |=> lvl); // R9
  AST_CLR_OVER_TOG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && !task_set[cfg.ch] && task_clr[cfg.ch]) |=> !lvl); // R9
  AST_TOG_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && !task_set[cfg.ch] && !task_clr[cfg.ch] && task_tog[cfg.ch])
      |=> (lvl != $past(lvl))); // R8
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |=> $stable(lvl)); // R10
endmodule

// File: rtl/pin_event_task_unit.sv
module pin_event_task_unit
  import pet_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [5:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [7:0]          evt_rise,
  output logic [7:0]          evt_fall,
  output logic [7:0]          evt_any,
  input  logic [7:0]          task_set,
  input  logic [7:0]          task_clr,
  input  logic [7:0]          task_tog,
  output logic [NUM_PINS-1:0] pin_out
);
  localparam int NUM_WORDS = NUM_PINS / PINS_PER_WORD;

  logic rst_q1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_i  <= rst_q1;
    end
  end

  logic [NUM_PINS-1:0] pin_sync;
  pet_sync #(.W(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     (pin_in),
    .q     (pin_sync)
  );

  evt_cfg_t evt_cfg_q [EVT_CH];
  evt_cfg_t evt_cfg_d [EVT_CH];
  tsk_cfg_t tsk_cfg_q [NUM_PINS];
  tsk_cfg_t tsk_cfg_d [NUM_PINS];

  logic [2:0] page;
  logic [2:0] idx;
  logic       evt_hit, tsk_hit;
  logic       unused_wdata;

  assign page = reg_addr[5:3];
  assign idx  = reg_addr[2:0];
  assign unused_wdata = ^reg_wdata;

  always_comb begin
    evt_hit = reg_we && (page == EVT_PAGE);
    tsk_hit = reg_we && (page == TSK_PAGE);
    for (int c = 0; c < EVT_CH; c++) evt_cfg_d[c] = evt_cfg_q[c];
    for (int p = 0; p < NUM_PINS; p++) tsk_cfg_d[p] = tsk_cfg_q[p];
    if (evt_hit) begin
      evt_cfg_d[idx].en  = reg_wdata[8];
      evt_cfg_d[idx].sel = reg_wdata[SEL_W-1:0];
    end
    for (int p = 0; p < NUM_PINS; p++) begin
      if (tsk_hit && (idx == 3'(p / PINS_PER_WORD))) begin
        tsk_cfg_d[p].en = reg_wdata[8*(p%PINS_PER_WORD)];
        tsk_cfg_d[p].ch = reg_wdata[8*(p%PINS_PER_WORD)+1 +: CH_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int c = 0; c < EVT_CH; c++) evt_cfg_q[c] <= '0;
      for (int p = 0; p < NUM_PINS; p++) tsk_cfg_q[p] <= '0;
    end else begin
      for (int c = 0; c < EVT_CH; c++) evt_cfg_q[c] <= evt_cfg_d[c];
      for (int p = 0; p < NUM_PINS; p++) tsk_cfg_q[p] <= tsk_cfg_d[p];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (page == EVT_PAGE) begin
      reg_rdata[8]         = evt_cfg_q[idx].en;
      reg_rdata[SEL_W-1:0] = evt_cfg_q[idx].sel;
    end else if (page == TSK_PAGE) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (idx == 3'(p / PINS_PER_WORD)) begin
          reg_rdata[8*(p%PINS_PER_WORD)]            = tsk_cfg_q[p].en;
          reg_rdata[8*(p%PINS_PER_WORD)+1 +: CH_W]  = tsk_cfg_q[p].ch;
        end
      end
    end
  end

  for (genvar c = 0; c < EVT_CH; c++) begin : gen_evt
    pet_evt_chan #(.NUM_PINS(NUM_PINS)) u_chan (
      .clk     (clk),
      .rst_n   (rst_i),
      .pin_lvl (pin_sync),
      .cfg     (evt_cfg_q[c]),
      .rise    (evt_rise[c]),
      .fall    (evt_fall[c]),
      .any     (evt_any[c])
    );
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : gen_pin
    pet_task_pin u_pin (
      .clk      (clk),
      .rst_n    (rst_i),
      .cfg      (tsk_cfg_q[p]),
      .task_set (task_set),
      .task_clr (task_clr),
      .task_tog (task_tog),
      .lvl      (pin_out[p])
    );
  end

  AST_EVT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_we && page == EVT_PAGE) |=> (evt_cfg_q[$past(idx)].sel == $past(reg_wdata[SEL_W-1:0]))); // R2
  AST_ANY_MATCHES: assert property (@(posedge clk) disable iff (!rst_i)
    (evt_any == (evt_rise | evt_fall))); // R3
  AST_WORDS_FIT: assert property (@(posedge clk) disable iff (!rst_i)
    (NUM_WORDS <= 8) && (NUM_PINS <= 32)); // R7
endmodule

// File: tb/pin_event_task_unit_tb.sv
module pin_event_task_unit_tb;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [NP-1:0] pin_in;
  logic [7:0]  evt_rise, evt_fall, evt_any;
  logic [7:0]  task_set, task_clr, task_tog;
  logic [NP-1:0] pin_out;

  int total = 0;
  int bad   = 0;

  logic [4:0]    m_sel [8];
  logic          m_en  [8];
  logic [2:0]    m_tch [NP];
  logic          m_ten [NP];
  logic [NP-1:0] m_out;
  logic [NP-1:0] m_pins;

  always #2.5 clk = ~clk;

  pin_event_task_unit #(.NUM_PINS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .evt_rise(evt_rise), .evt_fall(evt_fall), .evt_any(evt_any),
    .task_set(task_set), .task_clr(task_clr), .task_tog(task_tog),
    .pin_out(pin_out)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] evt_word(input int c);
    return {23'b0, m_en[c], 3'b0, m_sel[c]};
  endfunction

  function automatic logic [31:0] tsk_word(input int k);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++) begin
      w[8*b]       = m_ten[4*k+b];
      w[8*b+1 +: 3] = m_tch[4*k+b];
    end
    return w;
  endfunction

  function automatic logic [NP-1:0] next_out(input logic [NP-1:0] cur,
      input logic [7:0] s, input logic [7:0] c, input logic [7:0] t);
    logic [NP-1:0] n = cur;
    for (int p = 0; p < NP; p++) begin
      if (m_ten[p]) begin
        if (s[m_tch[p]])      n[p] = 1'b1;
        else if (c[m_tch[p]]) n[p] = 1'b0;
        else if (t[m_tch[p]]) n[p] = ~cur[p];
      end
    end
    return n;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a < 6'd8) begin
      m_sel[a[2:0]] = d[4:0];
      m_en[a[2:0]]  = d[8];
    end else if (a >= 6'd16 && a < 6'd16 + NP/4) begin
      for (int b = 0; b < 4; b++) begin
        m_ten[4*(a-16)+b] = d[8*b];
        m_tch[4*(a-16)+b] = d[8*b+1 +: 3];
      end
    end
  endtask

  task automatic rd_chk(input string rq, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(rq, reg_rdata, exp);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic evt_window(input string rq, input logic [NP-1:0] nv);
    logic [7:0] er, ef, ea;
    logic o, n;
    for (int c = 0; c < 8; c++) begin
      o = (m_sel[c] < NP) ? m_pins[m_sel[c][3:0]] : 1'b0;
      n = (m_sel[c] < NP) ? nv[m_sel[c][3:0]]     : 1'b0;
      er[c] = m_en[c] & n & ~o;
      ef[c] = m_en[c] & ~n & o;
      ea[c] = m_en[c] & (n ^ o);
    end
    @(negedge clk);
    pin_in = nv;
    m_pins = nv;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 3) chk(rq, {8'b0, evt_rise, evt_fall, evt_any}, {8'b0, er, ef, ea});
      else        chk(rq, {8'b0, evt_rise, evt_fall, evt_any}, 32'b0);
    end
  endtask

  task automatic tstep(input string rq, input logic [7:0] s, input logic [7:0] c, input logic [7:0] t);
    @(negedge clk);
    task_set = s; task_clr = c; task_tog = t;
    m_out = next_out(m_out, s, c, t);
    @(negedge clk);
    task_set = '0; task_clr = '0; task_tog = '0;
    chk(rq, {16'b0, pin_out}, {16'b0, m_out});
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    pin_in = '0; task_set = '0; task_clr = '0; task_tog = '0;
    for (int c = 0; c < 8; c++) begin m_sel[c] = '0; m_en[c] = 1'b0; end
    for (int p = 0; p < NP; p++) begin m_tch[p] = '0; m_ten[p] = 1'b0; end
    m_out = '0; m_pins = '0;

    repeat (4) @(negedge clk);
    chk("R1 outputs in reset", {evt_rise, evt_fall, evt_any, 8'b0}, 32'b0);
    chk("R1 pins in reset", {16'b0, pin_out}, 32'b0);
    @(negedge clk); rst_n = 1'b1;
    settle();
    rd_chk("R1 evt cfg after reset", 6'd0, 32'b0);
    rd_chk("R1 task word after reset", 6'd16, 32'b0);

    // R2: event config readback, garbage bits dropped
    wr(6'd3, 32'hFFFF_FE27);
    rd_chk("R2 evt readback", 6'd3, evt_word(3));
    // R7: task word readback, bits 7:4 of each byte read zero
    wr(6'd17, 32'hF3F0_A5FB);
    rd_chk("R7 task readback", 6'd17, tsk_word(1));

    // R5 / R4 / R6 directed: three channels on pin 7, one disabled, one out of range
    wr(6'd0, 32'h0000_0107);
    wr(6'd1, 32'h0000_0107);
    wr(6'd2, 32'h0000_0107);
    wr(6'd3, 32'h0000_0007);
    wr(6'd4, 32'h0000_0114);
    for (int c = 5; c < 8; c++) wr(6'(c), 32'h0);
    settle();
    evt_window("R5 shared pin rise", 16'h0080);
    evt_window("R3 shared pin fall", 16'h0000);
    evt_window("R4 R6 no pulse on other pins", 16'hFF7F);

    // random event windows (R3)
    for (int r = 0; r < 6; r++) begin
      for (int c = 0; c < 8; c++) wr(6'(c), $urandom() & 32'h0000_01FF & ~32'h0000_00E0 | (($urandom() % 20) & 32'h1F));
      settle();
      for (int w = 0; w < 6; w++) evt_window("R3 random edges", 16'($urandom()));
    end

    // R8 / R9 / R10 directed: pins 0..3 on channel 5, pin 8 disabled on channel 5
    wr(6'd16, 32'h0B0B_0B0B);
    wr(6'd17, 32'h0000_0000);
    wr(6'd18, 32'h0000_000A);
    wr(6'd19, 32'h0000_0000);
    settle();
    tstep("R8 set drives bound pins", 8'h20, 8'h00, 8'h00);
    tstep("R9 clr over tog", 8'h00, 8'h20, 8'h20);
    tstep("R8 toggle bound pins", 8'h00, 8'h00, 8'h20);
    tstep("R9 set over clr", 8'h20, 8'h20, 8'h20);
    tstep("R10 unbound channel no effect", 8'hDF, 8'h00, 8'hDF);
    chk("R10 disabled pin holds", {31'b0, pin_out[8]}, 32'b0);

    // random task traffic with random bindings (R8 R9 R10)
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < NP/4; k++) wr(6'(16 + k), $urandom());
      for (int k = 0; k < NP/4; k++) rd_chk("R7 random binding readback", 6'(16 + k), tsk_word(k));
      for (int i = 0; i < 40; i++)
        tstep("R8 random tasks", 8'($urandom()), 8'($urandom() & $urandom()), 8'($urandom()));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule